// File: doc/BRIEF.md
# Synchronous Data-Out Pacer for a Parallel Peripheral Bus

This block sends bytes, each already carrying its parity bit as a ninth bit, onto a parallel peripheral data bus using synchronous transfers. A request strobe is issued for every byte. The block does not wait for each byte's acknowledge before sending the next one. Instead, it keeps a credit count equal to the negotiated offset. Each strobe spends one credit, and each acknowledge pulse seen on the bus returns one. When no credit is left, no further byte is taken.

The strobe timing comes from a configured transfer period, given in 4 ns units, with an 8 ns core clock. Every byte has three phases:

- data setup before the strobe;
- strobe high;
- recovery after the strobe, before the next byte can be driven.

The setup and strobe widths take one of two fixed profiles: fast when the period is at most 25, slow above that. The recovery time is what remains of the period budget, limited to the range 0 to 15 cycles. An offset of zero means asynchronous operation, which this block does not handle; it then accepts nothing.

The `done` flag rises once three things are true: the input offers nothing, every byte sent has been acknowledged, and the acknowledge line is low. Configuration is taken only while the block is idle with all credits returned.

Top module: `scsi_sync_pacer`

## Requirements
- R1: While `rst` is high, `bus_req`, `in_ready` and `done` are 0 and `bus_data` is all zeros.
- R2: With an applied offset of 0, no byte is accepted (`in_ready` stays 0) and `bus_req` stays 0.
- R3: The number of strobes not yet matched by an acknowledge never exceeds the applied offset. `in_ready` is 1 only when the block is idle and at least one credit remains. After reset, no byte is taken until a configuration has been applied.
- R4: For a period of 25 or less, `bus_req` rises 3 cycles after the byte is accepted and stays high for 5 cycles.
- R5: For a period above 25, `bus_req` rises 6 cycles after acceptance and stays high for 12 cycles.
- R6: The recovery time after the strobe falls is floor(period*4/8) minus setup, minus width, minus 3, limited to 0..15 cycles. With input always offered and credit available, strobe rises are setup+width+recovery+1 cycles apart.
- R7: `ack_in` passes through a two-flop synchroniser. Each low-to-high transition returns one credit, three clock edges after the pin rises. A transition that arrives while the credits are full is ignored.
- R8: `done` is a registered flag. It is 1 in the cycle after one in which the block is idle, `in_valid` is 0, all credits are back and the synchronised acknowledge is low.
- R9: `cfg_offset` and `cfg_period` are applied only on a cycle where the block is idle, all credits are back and no byte is being accepted. Changes made during a transfer take effect after it completes.
- R10: `bus_data` takes the accepted byte on acceptance and holds it unchanged through the strobe. Bytes go out in the order accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, 8 ns period |
| rst | input | 1 | Synchronous active-high reset |
| cfg_offset | input | OFS_W | Negotiated offset: the maximum number of unacknowledged strobes; 0 selects asynchronous (idle) |
| cfg_period | input | PER_W | Transfer period in 4 ns units |
| in_valid | input | 1 | Source offers a byte |
| in_data | input | DATA_W | Byte with parity bit in the top position |
| in_ready | output | 1 | Byte is taken at the next edge when `in_valid` is 1 |
| ack_in | input | 1 | Acknowledge from the bus, asynchronous, active high |
| bus_data | output | DATA_W | Data driven to the bus |
| bus_req | output | 1 | Request strobe, active high |
| done | output | 1 | All bytes sent and acknowledged, acknowledge line low |

## Verification
The bench uses the default widths: a 5-bit offset, an 8-bit period and 9-bit data. It applies offsets of 3, 15, 2, 4 and 0 and periods of 50, 12, 100, 25 and 26. Periods 12 and 100 drive the recovery time to its lower and upper limits. Periods 25 and 26 sit on either side of the fast/slow boundary. The small offsets, together with a period during which the acknowledge pulses are held back, make the credit limit and the handling of excess acknowledges visible at `in_ready`.

// File: rtl/scsi_pacer_pkg.sv
package scsi_pacer_pkg;

  localparam int CNT_W           = 4;
  localparam int FAST_MAX_PERIOD = 25;
  localparam int FAST_SETUP      = 3;
  localparam int FAST_WIDTH      = 5;
  localparam int SLOW_SETUP      = 6;
  localparam int SLOW_WIDTH      = 12;
  localparam int FIXED_OVERHEAD  = 3;
  localparam int RECOVER_MAX     = 15;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ASSERT  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_t;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] width;
    logic [CNT_W-1:0] recover;
  } req_timing_t;

  // Period is in 4 ns units, the clock is 8 ns.
  function automatic req_timing_t derive_timing(input int period);
    req_timing_t t;
    int budget;
    int rec;
    budget = (period * 4) / 8;
    if (period <= FAST_MAX_PERIOD) begin
      t.setup = CNT_W'(FAST_SETUP);
      t.width = CNT_W'(FAST_WIDTH);
      rec     = budget - FAST_SETUP - FAST_WIDTH - FIXED_OVERHEAD;
    end else begin
      t.setup = CNT_W'(SLOW_SETUP);
      t.width = CNT_W'(SLOW_WIDTH);
      rec     = budget - SLOW_SETUP - SLOW_WIDTH - FIXED_OVERHEAD;
    end
    if (rec < 0)           rec = 0;
    if (rec > RECOVER_MAX) rec = RECOVER_MAX;
    t.recover = CNT_W'(rec);
    return t;
  endfunction

endpackage

// File: rtl/scsi_pacer_timing.sv
module scsi_pacer_timing
  import scsi_pacer_pkg::*;
#(
  parameter int OFS_W = 5,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic [PER_W-1:0] cfg_period,
  output logic [OFS_W-1:0] offset_q,
  output req_timing_t      timing_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_q <= '0;
      timing_q <= '0;
    end else if (load) begin
      offset_q <= cfg_offset;
      timing_q <= derive_timing(int'(cfg_period));
    end
  end

  // R4 / R5: once an offset is applied the strobe width is one of the two profiles
  a_r5_width_profile: assert property (@(posedge clk) disable iff (rst)
    (offset_q != '0) |-> (timing_q.width == CNT_W'(FAST_WIDTH) || timing_q.width == CNT_W'(SLOW_WIDTH)));

endmodule

// File: rtl/scsi_pacer_credit.sv
module scsi_pacer_credit #(
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_pin,
  input  logic             load,
  input  logic [OFS_W-1:0] load_value,
  input  logic [OFS_W-1:0] offset_q,
  input  logic             take,
  output logic [OFS_W-1:0] credit,
  output logic             ack_level
);

  logic sync1, sync2, sync3;
  logic ack_rise, give;

  assign ack_rise  = sync2 & ~sync3;
  assign give      = ack_rise && (credit < offset_q);
  assign ack_level = sync2;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= ack_pin;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      credit <= '0;
    end else if (load) begin
      credit <= load_value;
    end else begin
      case ({take, give})
        2'b10:   credit <= credit - OFS_W'(1);
        2'b01:   credit <= credit + OFS_W'(1);
        default: credit <= credit;
      endcase
    end
  end

  // R3: credits never exceed the applied offset
  a_r3_credit_bound: assert property (@(posedge clk) disable iff (rst)
    credit <= offset_q);

  // R7: without a strobe or reload, credit only stays or grows by one
  a_r7_single_return: assert property (@(posedge clk) disable iff (rst)
    (!load && !take) |=> (credit == $past(credit) || credit == $past(credit) + OFS_W'(1)));

endmodule

// File: rtl/scsi_pacer_fsm.sv
module scsi_pacer_fsm
  import scsi_pacer_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              credit_avail,
  input  req_timing_t       timing,
  output logic              in_ready,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_req,
  output logic              take,
  output logic              idle
);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign idle     = (phase == PH_IDLE);
  assign in_ready = idle && credit_avail;
  assign accept   = in_ready && in_valid;
  assign take     = (phase == PH_SETUP) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      bus_data <= '0;
      bus_req  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            bus_data <= in_data;
            cnt      <= timing.setup - CNT_W'(1);
            phase    <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            bus_req <= 1'b1;
            cnt     <= timing.width - CNT_W'(1);
            phase   <= PH_ASSERT;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_ASSERT: begin
          if (cnt == '0) begin
            bus_req <= 1'b0;
            if (timing.recover == '0) begin
              phase <= PH_IDLE;
            end else begin
              cnt   <= timing.recover - CNT_W'(1);
              phase <= PH_RECOVER;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - CNT_W'(1);
        end
      endcase
    end
  end

  // R10: bus data holds while a byte is in flight
  a_r10_data_stable: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(bus_data));

  // R3: a strobe starts only when a credit was available
  a_r3_req_needs_credit: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(credit_avail));

  // R4 / R5: the strobe is never high while idle
  a_r4_req_off_when_idle: assert property (@(posedge clk) disable iff (rst)
    idle |-> !bus_req);

endmodule

// File: rtl/scsi_sync_pacer.sv
module scsi_sync_pacer
  import scsi_pacer_pkg::*;
#(
  parameter int OFS_W  = 5,
  parameter int PER_W  = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  cfg_offset,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              ack_in,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_req,
  output logic              done
);

  logic [OFS_W-1:0] offset_q;
  logic [OFS_W-1:0] credit;
  req_timing_t      timing_q;
  logic             fsm_idle, take, ack_level, credit_full, cfg_load;

  assign credit_full = (credit == offset_q);
  assign cfg_load    = fsm_idle && credit_full && !(in_valid && in_ready);

  scsi_pacer_timing #(.OFS_W(OFS_W), .PER_W(PER_W)) u_timing (
    .clk        (clk),
    .rst        (rst),
    .load       (cfg_load),
    .cfg_offset (cfg_offset),
    .cfg_period (cfg_period),
    .offset_q   (offset_q),
    .timing_q   (timing_q)
  );

  scsi_pacer_credit #(.OFS_W(OFS_W)) u_credit (
    .clk        (clk),
    .rst        (rst),
    .ack_pin    (ack_in),
    .load       (cfg_load),
    .load_value (cfg_offset),
    .offset_q   (offset_q),
    .take       (take),
    .credit     (credit),
    .ack_level  (ack_level)
  );

  scsi_pacer_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .credit_avail (credit != '0),
    .timing       (timing_q),
    .in_ready     (in_ready),
    .bus_data     (bus_data),
    .bus_req      (bus_req),
    .take         (take),
    .idle         (fsm_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= fsm_idle && !in_valid && credit_full && !ack_level;
  end

  // R9: applied configuration changes only when idle and fully acknowledged
  a_r9_cfg_only_idle: assert property (@(posedge clk) disable iff (rst)
    !(fsm_idle && credit_full) |=> $stable(offset_q));

  // R2: zero offset keeps the bus silent
  a_r2_async_silent: assert property (@(posedge clk) disable iff (rst)
    (offset_q == '0) |-> (!bus_req && !in_ready));

  // R8: done never coexists with an active strobe
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_req);

endmodule

// File: tb/scsi_sync_pacer_bench.sv
module scsi_sync_pacer_bench;

  localparam int OFS_W = 5, PER_W = 8, DATA_W = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [OFS_W-1:0]  cfg_offset = '0;
  logic [PER_W-1:0]  cfg_period = '0;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              ack_in = 1'b0;
  logic              in_ready, bus_req, done;
  logic [DATA_W-1:0] bus_data;

  always #4 clk = ~clk;

  scsi_sync_pacer #(.OFS_W(OFS_W), .PER_W(PER_W), .DATA_W(DATA_W)) u_scsi_sync_pacer (
    .clk(clk), .rst(rst), .cfg_offset(cfg_offset), .cfg_period(cfg_period),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .ack_in(ack_in),
    .bus_data(bus_data), .bus_req(bus_req), .done(done)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic void delays(input int p, output int d0, output int d1, output int d2);
    int b;
    b  = p * 4 / 8;
    d0 = (p <= 25) ? 3 : 6;
    d1 = (p <= 25) ? 5 : 12;
    d2 = b - d0 - d1 - 3;
    if (d2 < 0)  d2 = 0;
    if (d2 > 15) d2 = 15;
  endfunction

  // ---------------- reference model ----------------
  int m_st, m_cnt, m_cr, m_off, m_d0, m_d1, m_d2;
  bit a1, a2, a3, m_req, m_done;
  logic [DATA_W-1:0] m_data;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_cr = 0; m_off = 0; m_d0 = 0; m_d1 = 0; m_d2 = 0;
      a1 = 0; a2 = 0; a3 = 0; m_req = 0; m_done = 0; m_data = '0;
    end else begin
      bit rise, acc, ld, take;
      int ncr;
      rise   = a2 && !a3;
      acc    = (m_st == 0) && (m_cr > 0) && in_valid;
      ld     = (m_st == 0) && (m_cr == m_off) && !acc;
      take   = (m_st == 1) && (m_cnt == 0);
      m_done = (m_st == 0) && !in_valid && (m_cr == m_off) && !a2;
      ncr = m_cr;
      if (ld) ncr = int'(cfg_offset);
      else begin
        if (take) ncr--;
        if (rise && m_cr < m_off) ncr++;
      end
      case (m_st)
        0: if (acc) begin m_data = in_data; m_st = 1; m_cnt = m_d0 - 1; end
        1: if (m_cnt == 0) begin m_req = 1; m_st = 2; m_cnt = m_d1 - 1; end else m_cnt--;
        2: if (m_cnt == 0) begin
             m_req = 0;
             if (m_d2 == 0) m_st = 0; else begin m_st = 3; m_cnt = m_d2 - 1; end
           end else m_cnt--;
        default: if (m_cnt == 0) m_st = 0; else m_cnt--;
      endcase
      if (ld) begin
        m_off = int'(cfg_offset);
        delays(int'(cfg_period), m_d0, m_d1, m_d2);
      end
      m_cr = ncr;
      a3 = a2; a2 = a1; a1 = ack_in;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check("R6", "bus_req", int'(bus_req), int'(m_req));
      check("R10", "bus_data", int'(bus_data), int'(m_data));
      check("R3", "in_ready", int'(in_ready), int'((m_st == 0) && (m_cr > 0)));
      check("R8", "done", int'(done), int'(m_done));
    end
  end

  // ---------------- acknowledge responder and measurements ----------------
  bit auto_ack = 0;
  int pending = 0, manual = 0, hi_left = 0, lo_left = 0;
  bit prev_req = 0;
  int rise_cyc = 0, last_rise = -1, w_min = 999, w_max = 0, iv_min = 999;
  logic [DATA_W-1:0] sent[$], got[$];

  always @(negedge clk) begin
    if (bus_req && !prev_req) begin
      if (last_rise >= 0 && (cyc - last_rise) < iv_min) iv_min = cyc - last_rise;
      last_rise = cyc;
      rise_cyc  = cyc;
      got.push_back(bus_data);
    end
    if (!bus_req && prev_req) begin
      if (cyc - rise_cyc < w_min) w_min = cyc - rise_cyc;
      if (cyc - rise_cyc > w_max) w_max = cyc - rise_cyc;
      pending++;
    end
    prev_req = bus_req;
    if (ack_in) begin
      hi_left--;
      if (hi_left == 0) begin ack_in = 0; lo_left = 2; end
    end else if (lo_left > 0) begin
      lo_left--;
    end else if (manual > 0) begin
      manual--; ack_in = 1; hi_left = 2;
    end else if (auto_ack && pending > 0) begin
      pending--; ack_in = 1; hi_left = 2;
    end
  end

  task automatic clr_stats();
    w_min = 999; w_max = 0; iv_min = 999; last_rise = -1;
    sent.delete(); got.delete();
  endtask

  task automatic push_try(input logic [DATA_W-1:0] b, input int limit, output bit ok);
    int n = 0;
    @(negedge clk);
    in_valid = 1; in_data = b;
    while (!in_ready && n < limit) begin @(negedge clk); n++; end
    ok = in_ready;
    if (ok) sent.push_back(b);
    else in_valid = 0;
  endtask

  task automatic push_n(input int cnt, input int base);
    bit ok;
    for (int i = 0; i < cnt; i++) push_try(DATA_W'(base + i * 37), 400, ok);
    @(negedge clk); in_valid = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!(done && !bus_req && pending == 0 && !ack_in) && n < 3000) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
    check(req, "done after stream", int'(done), 1);
  endtask

  task automatic check_order(input string req);
    check(req, "strobe count", got.size(), sent.size());
    for (int i = 0; i < sent.size() && i < got.size(); i++)
      check(req, "byte order", int'(got[i]), int'(sent[i]));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    finish_run();
  end

  initial begin
    int acc_cnt;
    bit ok;
    int d0, d1, d2;
    cfg_offset = 5'd3; cfg_period = 8'd50;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "bus_req in reset", int'(bus_req), 0);
    check("R1", "in_ready in reset", int'(in_ready), 0);
    check("R1", "done in reset", int'(done), 0);
    check("R1", "bus_data in reset", int'(bus_data), 0);
    rst = 0;
    repeat (4) @(negedge clk);

    // R7: extra acks while credits full are ignored; R3: limit of 3 outstanding
    manual = 3;
    repeat (30) @(negedge clk);
    clr_stats();
    acc_cnt = 0;
    for (int i = 0; i < 5; i++) begin
      push_try(DATA_W'(9'h100 + i), 200, ok);
      if (ok) acc_cnt++;
      if (!ok) break;
    end
    @(negedge clk); in_valid = 0;
    check("R3", "bytes taken without ack (offset 3)", acc_cnt, 3);
    check("R7", "excess acks gave no credit", acc_cnt, 3);
    check("R5", "slow width period 50", w_max, 12);
    auto_ack = 1;
    push_n(2, 9'h055);
    wait_done("R8");
    check_order("R10");

    // R4 / R6: fast timing, recovery clamped to 0
    cfg_offset = 5'd15; cfg_period = 8'd12;
    repeat (5) @(negedge clk);
    clr_stats();
    push_n(20, 9'h0A3);
    wait_done("R8");
    check("R4", "fast width period 12", w_max, 5);
    check("R4", "fast width min period 12", w_min, 5);
    check("R6", "interval period 12 (recovery 0)", iv_min, 9);
    check_order("R10");

    // R6 upper clamp; R9: config changed mid-stream is deferred
    cfg_offset = 5'd2; cfg_period = 8'd100;
    repeat (5) @(negedge clk);
    clr_stats();
    push_try(9'h1F0, 400, ok);
    cfg_offset = 5'd7; cfg_period = 8'd12;
    push_n(5, 9'h011);
    wait_done("R8");
    delays(100, d0, d1, d2);
    check("R9", "width unchanged mid-stream", w_min, d1);
    check("R6", "interval period 100 (recovery 15)", iv_min, d0 + d1 + d2 + 1);
    check_order("R10");
    clr_stats();
    push_n(3, 9'h0C0);
    wait_done("R8");
    check("R9", "new period applied when idle", w_max, 5);

    // R4 / R5 boundary: 25 fast, 26 slow
    cfg_offset = 5'd4; cfg_period = 8'd25;
    repeat (5) @(negedge clk);
    clr_stats();
    push_n(6, 9'h0E1);
    wait_done("R8");
    check("R4", "width period 25", w_max, 5);
    check("R6", "interval period 25", iv_min, 10);
    cfg_period = 8'd26;
    repeat (5) @(negedge clk);
    clr_stats();
    push_n(3, 9'h013);
    wait_done("R8");
    check("R5", "width period 26", w_max, 12);

    // R2: offset zero accepts nothing
    cfg_offset = 5'd0;
    repeat (5) @(negedge clk);
    clr_stats();
    push_try(9'h0AA, 60, ok);
    @(negedge clk); in_valid = 0;
    check("R2", "byte accepted at offset 0", int'(ok), 0);
    check("R2", "strobes at offset 0", got.size(), 0);
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule